// File: doc/BRIEF.md
# Interrupt request latch and arbiter

This block gathers the interrupt requests of a small 8-bit controller core and hands the instruction sequencer one request at a time, together with the address of the vector word to fetch. Three maskable sources are captured in latches: an external pin on a programmable edge, a timeout pulse from the real-time timer, and falling edges on eight wake-up port pins, each pin with its own enable. Every latch output crosses a two-stage synchronizer before it can raise a request. The core's global interrupt mask is an input; while it is set, no maskable source reaches the sequencer, although the latches keep capturing.

The software trap is not maskable. When the trap opcode is fetched, the block records which hardware sources are visible at that moment. Those sources are presented first, and the trap is presented as soon as all of them have been cleared. Hardware requests that appear after the fetch wait until the trap is acknowledged. The sequencer clears each hardware latch with a one-cycle strobe early in its service routine, so a fresh edge can be held again while the global mask is still set.

The ordering state machine has three states. IDLE: no trap outstanding. SWI_WAIT: a trap has been fetched while older hardware requests are visible. SWI_GO: the trap is presented. The transitions are: IDLE to SWI_WAIT on a fetch while the mask is clear and some hardware source is visible; IDLE to SWI_GO on any other fetch; SWI_WAIT to SWI_GO once no recorded source is still visible, or when the mask gets set; SWI_GO to IDLE on the trap acknowledge.

Top module: `irq_arbiter`

## Requirements
- R1: A trap fetch in IDLE leads to `irq_is_swi`=1, `irq_req`=1 and `irq_vector`=16'hFFFC whatever `gmask` holds. These values stay until `swi_ack`, and `irq_is_swi` is 0 in the cycle after `swi_ack`.
- R2: With `gmask`=0, a trap fetched while hardware requests are visible is held back (`irq_is_swi`=0, `irq_vector`=16'hFFFA) until every source that was visible at the fetch has been cleared.
- R3: After the recorded sources are cleared, the trap is presented ahead of any hardware request that arrived after the fetch. That request is presented once the trap is acknowledged.
- R4: While `gmask`=1, `irq_req` is 0 unless the trap is presented. Clearing `gmask` presents any held request in the same cycle.
- R5: Control register 0x0E bit 1 selects the external edge: 0 for falling (the reset value) and 1 for rising. An edge of the other polarity latches nothing.
- R6: Control register 0x0E bit 0 enables the external request. A latched request that is disabled raises no `irq_req`, but reads back as 0x0E bit 7, and it is presented once bit 0 is set.
- R7: A `rti_tick` pulse is latched. Register 0x18 bit 0 gates it, and 0x18 bit 7 reads back the synchronized latch.
- R8: A falling edge on `wake_pins[i]` is latched only when bit i of register 0x13 is 1. Falling edges on disabled pins are ignored.
- R9: Every hardware source is presented with `irq_vector`=16'hFFFA and `irq_is_swi`=0.
- R10: `clr_src` bit 0 clears the external latch, bit 1 the real-time latch and bit 2 the wake-up latch. The request falls in the cycle after the strobe. An external edge captured after the clear is held while `gmask`=1.
- R11: After reset, registers 0x0E, 0x18 and 0x13 read 0, all latches are empty and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| rti_tick | input | 1 | One-cycle timeout pulse from the real-time timer |
| wake_pins | input | 8 | Wake-up port pins, asynchronous |
| gmask | input | 1 | Global interrupt mask from the core, 1 blocks maskable sources |
| swi_fetch | input | 1 | Pulse when the trap opcode is fetched |
| swi_ack | input | 1 | Pulse when the sequencer takes the trap |
| clr_src | input | 3 | Latch clear strobes: bit 0 external, bit 1 real-time, bit 2 wake-up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_req | output | 1 | A request is presented to the sequencer |
| irq_is_swi | output | 1 | The presented request is the trap |
| irq_vector | output | 16 | Address of the high byte of the vector word |

## Verification
The assertions take for granted that `swi_fetch` pulses only while the machine is in IDLE, that `swi_ack` pulses only while the trap is presented, and that `rti_tick` and the strobes are synchronous to `clk`. The directed stimulus drives every input at the falling clock edge. It sends a fetch only after the previous trap has been acknowledged, and it holds each pin level for eight cycles, so that every edge passes through the synchronizers before the next edge arrives.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SWI_WAIT = 2'd1,
        ST_SWI_GO   = 2'd2
    } arb_state_t;

    localparam int NSRC = 3;
    localparam int SRC_EXT  = 0;
    localparam int SRC_RTI  = 1;
    localparam int SRC_WAKE = 2;

    localparam logic [7:0] ADDR_EXT_CTL = 8'h0E;
    localparam logic [7:0] ADDR_WAKE_EN = 8'h13;
    localparam logic [7:0] ADDR_RTI_CTL = 8'h18;

    localparam logic [15:0] VEC_HW  = 16'hFFFA;
    localparam logic [15:0] VEC_SWI = 16'hFFFC;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d & ~clr;
            q  <= s1 & ~clr;
        end
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int NPORT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             ext_stat,
    input  logic             rti_stat,
    output logic [7:0]       reg_rdata,
    output logic             ext_en,
    output logic             ext_rise,
    output logic             rti_en,
    output logic [NPORT-1:0] wake_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_en   <= 1'b0;
            ext_rise <= 1'b0;
            rti_en   <= 1'b0;
            wake_en  <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADDR_EXT_CTL: begin
                    ext_en   <= reg_wdata[0];
                    ext_rise <= reg_wdata[1];
                end
                ADDR_RTI_CTL: rti_en  <= reg_wdata[0];
                ADDR_WAKE_EN: wake_en <= reg_wdata[NPORT-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_EXT_CTL: reg_rdata = {ext_stat, 5'b0, ext_rise, ext_en};
            ADDR_RTI_CTL: reg_rdata = {rti_stat, 6'b0, rti_en};
            ADDR_WAKE_EN: reg_rdata[NPORT-1:0] = wake_en;
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_order_fsm.sv
module irq_order_fsm
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gmask,
    input  logic            swi_fetch,
    input  logic            swi_ack,
    input  logic [NSRC-1:0] hw_vis,
    output arb_state_t      state,
    output logic            irq_req,
    output logic            irq_is_swi,
    output logic [15:0]     irq_vector
);
    arb_state_t      state_nx;
    logic [NSRC-1:0] snap;
    logic [NSRC-1:0] snap_nx;

    always_comb begin
        state_nx = state;
        snap_nx  = snap & hw_vis;
        unique case (state)
            ST_IDLE: begin
                if (swi_fetch) begin
                    snap_nx  = hw_vis;
                    state_nx = (!gmask && hw_vis != '0) ? ST_SWI_WAIT : ST_SWI_GO;
                end
            end
            ST_SWI_WAIT: begin
                if (gmask || (snap & hw_vis) == '0)
                    state_nx = ST_SWI_GO;
            end
            ST_SWI_GO: begin
                if (swi_ack)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            snap  <= '0;
        end else begin
            state <= state_nx;
            snap  <= snap_nx;
        end
    end

    always_comb begin
        irq_is_swi = (state == ST_SWI_GO);
        irq_req    = irq_is_swi || (hw_vis != '0);
        irq_vector = irq_is_swi ? VEC_SWI : VEC_HW;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NPORT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             rti_tick,
    input  logic [NPORT-1:0] wake_pins,
    input  logic             gmask,
    input  logic             swi_fetch,
    input  logic             swi_ack,
    input  logic [2:0]       clr_src,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq_req,
    output logic             irq_is_swi,
    output logic [15:0]      irq_vector
);
    localparam int PW = NPORT + 1;

    logic [PW-1:0]   pin_s, pin_p;
    logic            ext_en, ext_rise, rti_en;
    logic [NPORT-1:0] wake_en;
    logic            ext_edge, wake_hit;
    logic [NSRC-1:0] src_set, lat, lat_s, src_en, hw_vis;
    arb_state_t      state;

    irq_sync2 #(.W(PW)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .clr('0),
        .d({wake_pins, ext_pin}), .q(pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_p <= '0;
        else        pin_p <= pin_s;
    end

    assign ext_edge = ext_rise ? (pin_s[0] & ~pin_p[0]) : (~pin_s[0] & pin_p[0]);
    assign wake_hit = |(~pin_s[PW-1:1] & pin_p[PW-1:1] & wake_en);

    always_comb begin
        src_set = '0;
        src_set[SRC_EXT]  = ext_edge;
        src_set[SRC_RTI]  = rti_tick;
        src_set[SRC_WAKE] = wake_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= '0;
        else        lat <= (lat & ~clr_src) | src_set;
    end

    irq_sync2 #(.W(NSRC)) u_lat_sync (
        .clk(clk), .rst_n(rst_n), .clr(clr_src),
        .d(lat), .q(lat_s)
    );

    always_comb begin
        src_en = '0;
        src_en[SRC_EXT]  = ext_en;
        src_en[SRC_RTI]  = rti_en;
        src_en[SRC_WAKE] = |wake_en;
    end

    assign hw_vis = lat_s & src_en & {NSRC{~gmask}};

    irq_regs #(.NPORT(NPORT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ext_stat(lat_s[SRC_EXT]), .rti_stat(lat_s[SRC_RTI]),
        .reg_rdata(reg_rdata), .ext_en(ext_en), .ext_rise(ext_rise),
        .rti_en(rti_en), .wake_en(wake_en)
    );

    irq_order_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .gmask(gmask), .swi_fetch(swi_fetch),
        .swi_ack(swi_ack), .hw_vis(hw_vis), .state(state), .irq_req(irq_req),
        .irq_is_swi(irq_is_swi), .irq_vector(irq_vector)
    );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_pkg::*;
#(
    parameter int NPORT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gmask,
    input logic             swi_fetch,
    input logic             swi_ack,
    input logic             rti_tick,
    input logic [2:0]       clr_src,
    input logic             irq_req,
    input logic             irq_is_swi,
    input arb_state_t       state,
    input logic             ext_edge,
    input logic [NSRC-1:0]  lat,
    input logic [NPORT-1:0] wake_en
);
    p_swi_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        swi_fetch && gmask && state == ST_IDLE |=> irq_is_swi);

    p_swi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_is_swi && !swi_ack |=> irq_is_swi);

    p_swi_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_is_swi && swi_ack |=> !irq_is_swi);

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gmask && !irq_is_swi |-> !irq_req);

    p_tick_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |=> lat[SRC_RTI]);

    p_wake_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_en == '0 |=> !$rose(lat[SRC_WAKE]));

    p_ext_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_src[SRC_EXT] && !ext_edge |=> !lat[SRC_EXT]);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .gmask(gmask), .swi_fetch(swi_fetch),
    .swi_ack(swi_ack), .rti_tick(rti_tick), .clr_src(clr_src),
    .irq_req(irq_req), .irq_is_swi(irq_is_swi), .state(state),
    .ext_edge(ext_edge), .lat(lat), .wake_en(wake_en)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b1;
    logic        rti_tick = 1'b0;
    logic [7:0]  wake_pins = 8'hFF;
    logic        gmask = 1'b0;
    logic        swi_fetch = 1'b0;
    logic        swi_ack = 1'b0;
    logic [2:0]  clr_src = 3'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_req, irq_is_swi;
    logic [15:0] irq_vector;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .rti_tick(rti_tick),
        .wake_pins(wake_pins), .gmask(gmask), .swi_fetch(swi_fetch),
        .swi_ack(swi_ack), .clr_src(clr_src), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_is_swi(irq_is_swi), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clr(input logic [2:0] m);
        @(negedge clk);
        clr_src = m;
        @(negedge clk);
        clr_src = 3'b0;
    endtask

    task automatic pulse_fetch();
        @(negedge clk); swi_fetch = 1'b1;
        @(negedge clk); swi_fetch = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); swi_ack = 1'b1;
        @(negedge clk); swi_ack = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); rti_tick = 1'b1;
        @(negedge clk); rti_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h0E, d); chk("R11 ext ctl reset", d, 8'h00);
        rd(8'h18, d); chk("R11 rti ctl reset", d, 8'h00);
        rd(8'h13, d); chk("R11 wake en reset", d, 8'h00);
        chk("R11 no request", irq_req, 1'b0);
    endtask

    task automatic t_ext_edges();
        wr(8'h0E, 8'h01);
        @(negedge clk); ext_pin = 1'b0; cyc(8);
        chk("R5 falling latched", irq_req, 1'b1);
        chk("R9 hw vector", irq_vector, 16'hFFFA);
        chk("R9 not trap", irq_is_swi, 1'b0);
        clr(3'b001);
        chk("R10 ext cleared", irq_req, 1'b0);
        ext_pin = 1'b1; cyc(8);
        chk("R5 rising ignored", irq_req, 1'b0);
        wr(8'h0E, 8'h03);
        ext_pin = 1'b0; cyc(8);
        chk("R5 falling ignored in rise mode", irq_req, 1'b0);
        ext_pin = 1'b1; cyc(8);
        chk("R5 rising latched", irq_req, 1'b1);
        clr(3'b001);
        chk("R10 ext cleared again", irq_req, 1'b0);
        wr(8'h0E, 8'h01);
    endtask

    task automatic t_ext_disabled();
        logic [7:0] d;
        wr(8'h0E, 8'h00);
        ext_pin = 1'b0; cyc(8);
        chk("R6 disabled no request", irq_req, 1'b0);
        rd(8'h0E, d); chk("R6 status bit set", d, 8'h80);
        wr(8'h0E, 8'h01);
        chk("R6 enabled presents", irq_req, 1'b1);
        clr(3'b001);
        chk("R10 cleared", irq_req, 1'b0);
        rd(8'h0E, d); chk("R6 status cleared", d, 8'h01);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        gmask = 1'b1;
        ext_pin = 1'b1; cyc(8);
        ext_pin = 1'b0; cyc(8);
        chk("R4 mask blocks ext", irq_req, 1'b0);
        gmask = 1'b0; #1;
        chk("R4 unmask presents", irq_req, 1'b1);
        gmask = 1'b1;
        clr(3'b001);
        ext_pin = 1'b1; cyc(8);
        ext_pin = 1'b0; cyc(8);
        chk("R10 new edge held under mask", irq_req, 1'b0);
        rd(8'h0E, d); chk("R10 new edge latched", d, 8'h81);
        gmask = 1'b0; #1;
        chk("R10 held edge presented", irq_req, 1'b1);
        clr(3'b001);
        chk("R10 held edge cleared", irq_req, 1'b0);
    endtask

    task automatic t_rti();
        logic [7:0] d;
        pulse_tick(); cyc(4);
        chk("R7 disabled no request", irq_req, 1'b0);
        rd(8'h18, d); chk("R7 status bit", d, 8'h80);
        wr(8'h18, 8'h01);
        chk("R7 enabled presents", irq_req, 1'b1);
        chk("R9 rti vector", irq_vector, 16'hFFFA);
        clr(3'b010);
        chk("R10 rti cleared", irq_req, 1'b0);
        rd(8'h18, d); chk("R7 status cleared", d, 8'h01);
    endtask

    task automatic t_wake();
        wr(8'h13, 8'h04);
        @(negedge clk); wake_pins[3] = 1'b0; cyc(8);
        chk("R8 disabled pin ignored", irq_req, 1'b0);
        wake_pins[2] = 1'b0; cyc(8);
        chk("R8 enabled pin latched", irq_req, 1'b1);
        chk("R9 wake vector", irq_vector, 16'hFFFA);
        clr(3'b100);
        chk("R10 wake cleared", irq_req, 1'b0);
        wake_pins = 8'hFF; cyc(8);
        chk("R8 rising edge ignored", irq_req, 1'b0);
    endtask

    task automatic t_swi_masked();
        gmask = 1'b1;
        pulse_fetch();
        chk("R1 trap under mask", irq_is_swi, 1'b1);
        chk("R1 request", irq_req, 1'b1);
        chk("R1 trap vector", irq_vector, 16'hFFFC);
        cyc(3);
        chk("R1 held until ack", irq_is_swi, 1'b1);
        pulse_ack();
        chk("R1 released by ack", irq_is_swi, 1'b0);
        chk("R1 nothing left", irq_req, 1'b0);
        gmask = 1'b0;
    endtask

    task automatic t_order();
        ext_pin = 1'b1; cyc(8);
        ext_pin = 1'b0; cyc(8);
        pulse_tick(); cyc(4);
        chk("R2 hw pending before fetch", irq_req, 1'b1);
        pulse_fetch();
        chk("R2 trap waits", irq_is_swi, 1'b0);
        chk("R2 hw vector first", irq_vector, 16'hFFFA);
        clr(3'b001);
        chk("R2 trap still waits for rti", irq_is_swi, 1'b0);
        chk("R2 rti still presented", irq_req, 1'b1);
        wr(8'h13, 8'h01);
        wake_pins[0] = 1'b0; cyc(8);
        clr(3'b010);
        cyc(1);
        chk("R3 trap ahead of later wake", irq_is_swi, 1'b1);
        chk("R3 trap vector", irq_vector, 16'hFFFC);
        pulse_ack();
        chk("R3 wake after ack", irq_is_swi, 1'b0);
        chk("R3 wake presented", irq_req, 1'b1);
        chk("R3 wake vector", irq_vector, 16'hFFFA);
        clr(3'b100);
        chk("R10 all clear", irq_req, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        t_reset();
        t_ext_edges();
        t_ext_disabled();
        t_mask();
        t_rti();
        t_wake();
        t_swi_masked();
        t_order();
        cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule